// File: doc/BRIEF.md
# Single-Wire Debug Link Guard

This block sits on a half-duplex, open-drain debug wire shared by a host and the chip. It learns the host's bit period from a sync character, receives and sends 8N1 characters at that period, and watches the wire for three faults. These are a held-low break, a bad stop bit, and the host pulling the wire low while the block is sending. When it sees any of them, the block cancels the character in flight and signals an abort to the command logic. It then pulls the wire low for a fixed number of clocks as a break answer and forgets the learned bit period.

The wire is never driven high. The block only asserts a pull-low enable, and the level it reads back (`line_i`) is already synchronised to `clk_i`. After a fault the link stays in reset until the wire is seen high again. The host then sends the sync character 0x80 to restart the rate measurement. Any command or mode state kept outside this block is untouched by this sequence. Only the rate logic and the serial engines restart.

Top module: `dbg_link_guard`

## Requirements
- R1: While unlocked, the block measures each low run of the wire. On the rise at the end of a run it takes the run length divided by eight as the bit period and sets `locked_o`. The sync character 0x80 (start bit plus seven zero data bits, LSB first) therefore yields exactly one bit period.
- R2: A low run whose period (length / 8) is below `MIN_PER`, or whose length saturates the counter, does not lock. No `rx_valid_o` pulse occurs while `locked_o` is low, and the sync character itself is not delivered.
- R3: When locked, a falling edge starts a receive. Bits are sampled half a period after that edge and then once per period: start bit, data LSB first, then stop bit. A high stop bit gives a one-cycle `rx_valid_o` with the byte on `rx_data_o`.
- R4: When locked and idle with the wire high, `tx_valid_i` starts a frame on `pull_low_o` at the learned period. The frame is a start bit (low), data LSB first, and a stop bit (released). `pull_low_o` is high only for zero bits, and `tx_valid_i` has no effect while unlocked.
- R5: A low stop bit that does not complete a break run raises `err_frame_o`.
- R6: A low stop bit with the wire continuously low for at least nine bit periods raises `err_break_o` instead of `err_frame_o`.
- R7: While sending, a wire sampled low in mid-period during a released (one) bit raises `err_coll_o` and stops the transmit.
- R8: Every fault gives a one-cycle `abort_o` together with exactly one of the three flags, cancels receive and transmit, and clears `locked_o`.
- R9: Beginning one cycle after the fault is detected, `pull_low_o` is held high for exactly `BRK_LEN` cycles (4096 by default).
- R10: `link_rst_o` rises with the break answer and stays high until the first cycle after the answer in which the wire is high. The rate must then be learned again with 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| line_i | input | 1 | Synchronised wire level |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Send request strobe |
| tx_busy_o | output | 1 | Transmit frame in progress |
| pull_low_o | output | 1 | Open-drain pull-low enable |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle received-byte strobe |
| abort_o | output | 1 | One-cycle command abort |
| link_rst_o | output | 1 | Link held in reset |
| locked_o | output | 1 | Bit period learned |
| err_break_o | output | 1 | Break fault pulse |
| err_frame_o | output | 1 | Framing fault pulse |
| err_coll_o | output | 1 | Collision fault pulse |

## Verification
Receive and transmit are tried with random bytes at two learned rates, 16 and 24 clocks per bit. Passing at both rates shows that the period really comes from the measured sync run and is not a fixed constant. An alternating 0x55 pattern sent before lock shows that short low runs are rejected and nothing is delivered. The three faults are produced by a low stop bit after mixed data, a long held-low wire, and a host pull during a ones byte. Each fault is told apart by which flag pulses, and each is followed by an answer length check, a wait for the wire to go high, and a relock.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
    typedef enum logic [1:0] {
        LK_RUN,
        LK_REPLY,
        LK_WAITHI
    } link_st_e;
endpackage

// File: rtl/dbg_autobaud.sv
module dbg_autobaud #(
    parameter int CW      = 12,
    parameter int MIN_PER = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          line_i,
    output logic          locked_o,
    output logic [CW-1:0] period_o
);
    localparam int AW = CW + 3;

    typedef struct packed {
        logic          locked;
        logic [CW-1:0] period;
        logic [AW-1:0] cnt;
        logic          sat;
    } ab_s;

    ab_s ab_d, ab_q;

    always_comb begin
        ab_d = ab_q;
        if (clear_i) begin
            ab_d = '0;
        end else if (!ab_q.locked) begin
            if (!line_i) begin
                if (&ab_q.cnt) ab_d.sat = 1'b1;
                else           ab_d.cnt = ab_q.cnt + AW'(1);
            end else if (ab_q.cnt != '0 || ab_q.sat) begin
                // period = run length / 8 (low part of the sync character)
                if (!ab_q.sat && ab_q.cnt[AW-1:3] >= CW'(MIN_PER)) begin
                    ab_d.locked = 1'b1;
                    ab_d.period = ab_q.cnt[AW-1:3];
                end
                ab_d.cnt = '0;
                ab_d.sat = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ab_q <= '0;
        else         ab_q <= ab_d;
    end

    assign locked_o = ab_q.locked;
    assign period_o = ab_q.period;

    // R1: a learned period stays put until the link is cleared
    a_r1_period_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !clear_i) |=> $stable(period_o));
    // R2: a lock never carries a period below the floor
    a_r2_period_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> (period_o >= CW'(MIN_PER)));
endmodule

// File: rtl/dbg_rx.sv
module dbg_rx #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          line_i,
    input  logic [CW-1:0] period_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [7:0]    data_o,
    output logic          frm_o,
    output logic          brk_o
);
    localparam int LW = CW + 4;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] tmr;
        logic [3:0]    bitn;
        logic [7:0]    sh;
        logic [LW-1:0] lc;
        logic          done;
        logic          frm;
        logic          brk;
    } rx_s;

    rx_s rx_d, rx_q;
    logic [LW-1:0] nine_bits;

    always_comb begin
        nine_bits = ({4'b0, period_i} << 3) + {4'b0, period_i};
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        rx_d.frm  = 1'b0;
        rx_d.brk  = 1'b0;
        if (line_i)         rx_d.lc = '0;
        else if (~&rx_q.lc) rx_d.lc = rx_q.lc + LW'(1);

        if (!en_i) begin
            rx_d.active = 1'b0;
        end else if (!rx_q.active) begin
            if (!line_i) begin
                rx_d.active = 1'b1;
                rx_d.tmr    = (period_i >> 1) - CW'(1);
                rx_d.bitn   = 4'd0;
            end
        end else if (rx_q.tmr != '0) begin
            rx_d.tmr = rx_q.tmr - CW'(1);
        end else begin
            rx_d.tmr = period_i - CW'(1);
            if (rx_q.bitn == 4'd0) begin
                if (line_i) rx_d.active = 1'b0;
                else        rx_d.bitn   = 4'd1;
            end else if (rx_q.bitn <= 4'd8) begin
                rx_d.sh   = {line_i, rx_q.sh[7:1]};
                rx_d.bitn = rx_q.bitn + 4'd1;
            end else begin
                rx_d.active = 1'b0;
                if (line_i)                  rx_d.done = 1'b1;
                else if (rx_q.lc >= nine_bits) rx_d.brk = 1'b1;
                else                         rx_d.frm  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rx_q <= '0;
        else         rx_q <= rx_d;
    end

    assign busy_o = rx_q.active;
    assign done_o = rx_q.done;
    assign data_o = rx_q.sh;
    assign frm_o  = rx_q.frm;
    assign brk_o  = rx_q.brk;

    // R3: a delivered byte had its stop bit sampled high
    a_r3_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(line_i));
    // R6: a break or framing result always saw a low stop bit
    a_r6_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (brk_o || frm_o) |-> !$past(line_i));
endmodule

// File: rtl/dbg_tx.sv
module dbg_tx #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          start_i,
    input  logic [7:0]    data_i,
    input  logic [CW-1:0] period_i,
    input  logic          line_i,
    output logic          busy_o,
    output logic          pull_o,
    output logic          coll_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] tmr;
        logic [3:0]    bitn;
        logic [9:0]    sh;
        logic          pull;
        logic          coll;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.coll = 1'b0;
        if (!en_i) begin
            tx_d.busy = 1'b0;
            tx_d.pull = 1'b0;
        end else if (!tx_q.busy) begin
            if (start_i) begin
                tx_d.busy = 1'b1;
                tx_d.sh   = {1'b1, data_i, 1'b0};
                tx_d.pull = 1'b1;
                tx_d.bitn = 4'd0;
                tx_d.tmr  = period_i - CW'(1);
            end
        end else if (tx_q.tmr == (period_i >> 1) && tx_q.sh[0] && !line_i) begin
            tx_d.coll = 1'b1;
            tx_d.busy = 1'b0;
            tx_d.pull = 1'b0;
        end else if (tx_q.tmr != '0) begin
            tx_d.tmr = tx_q.tmr - CW'(1);
        end else if (tx_q.bitn == 4'd9) begin
            tx_d.busy = 1'b0;
            tx_d.pull = 1'b0;
        end else begin
            tx_d.sh   = {1'b1, tx_q.sh[9:1]};
            tx_d.bitn = tx_q.bitn + 4'd1;
            tx_d.pull = ~tx_q.sh[1];
            tx_d.tmr  = period_i - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tx_q <= '0;
        else         tx_q <= tx_d;
    end

    assign busy_o = tx_q.busy;
    assign pull_o = tx_q.pull;
    assign coll_o = tx_q.coll;

    // R4: the wire is only pulled low inside a frame
    a_r4_pull_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pull_o |-> busy_o);
    // R7: a collision ends the frame and releases the wire
    a_r7_coll_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll_o |-> (!busy_o && !pull_o));
endmodule

// File: rtl/dbg_link_guard.sv
module dbg_link_guard
    import dbg_link_pkg::*;
#(
    parameter int CW      = 12,
    parameter int MIN_PER = 4,
    parameter int BRK_LEN = 4096
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       line_i,
    input  logic [7:0] tx_data_i,
    input  logic       tx_valid_i,
    output logic       tx_busy_o,
    output logic       pull_low_o,
    output logic [7:0] rx_data_o,
    output logic       rx_valid_o,
    output logic       abort_o,
    output logic       link_rst_o,
    output logic       locked_o,
    output logic       err_break_o,
    output logic       err_frame_o,
    output logic       err_coll_o
);
    localparam int RW = $clog2(BRK_LEN);

    typedef struct packed {
        link_st_e      st;
        logic [RW-1:0] rcnt;
        logic          abort;
        logic          eb;
        logic          ef;
        logic          ec;
    } top_s;

    top_s tp_d, tp_q;

    logic          run, ab_clear;
    logic [CW-1:0] period;
    logic          rx_en, rx_busy, rx_done, rx_frm, rx_brk;
    logic          tx_en, tx_start, tx_pull, tx_coll;
    logic          fault;

    assign run      = (tp_q.st == LK_RUN);
    assign ab_clear = !run;
    assign rx_en    = run && locked_o && !tx_busy_o;
    assign tx_en    = run && locked_o && !rx_busy && !rx_brk && !rx_frm;
    assign tx_start = tx_valid_i && line_i;
    assign fault    = run && (rx_brk || rx_frm || tx_coll);

    dbg_autobaud #(.CW(CW), .MIN_PER(MIN_PER)) u_baud (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (ab_clear),
        .line_i   (line_i),
        .locked_o (locked_o),
        .period_o (period)
    );

    dbg_rx #(.CW(CW)) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (rx_en),
        .line_i   (line_i),
        .period_i (period),
        .busy_o   (rx_busy),
        .done_o   (rx_done),
        .data_o   (rx_data_o),
        .frm_o    (rx_frm),
        .brk_o    (rx_brk)
    );

    dbg_tx #(.CW(CW)) u_tx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (tx_en),
        .start_i  (tx_start),
        .data_i   (tx_data_i),
        .period_i (period),
        .line_i   (line_i),
        .busy_o   (tx_busy_o),
        .pull_o   (tx_pull),
        .coll_o   (tx_coll)
    );

    always_comb begin
        tp_d       = tp_q;
        tp_d.abort = 1'b0;
        tp_d.eb    = 1'b0;
        tp_d.ef    = 1'b0;
        tp_d.ec    = 1'b0;
        case (tp_q.st)
            LK_RUN: begin
                if (fault) begin
                    tp_d.st    = LK_REPLY;
                    tp_d.rcnt  = RW'(BRK_LEN - 1);
                    tp_d.abort = 1'b1;
                    tp_d.eb    = rx_brk;
                    tp_d.ef    = rx_frm && !rx_brk;
                    tp_d.ec    = tx_coll && !rx_brk && !rx_frm;
                end
            end
            LK_REPLY: begin
                if (tp_q.rcnt == '0) tp_d.st   = LK_WAITHI;
                else                 tp_d.rcnt = tp_q.rcnt - RW'(1);
            end
            LK_WAITHI: begin
                if (line_i) tp_d.st = LK_RUN;
            end
            default: tp_d.st = LK_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tp_q <= '{st: LK_RUN, default: '0};
        else         tp_q <= tp_d;
    end

    assign pull_low_o  = (tp_q.st == LK_REPLY) || tx_pull;
    assign link_rst_o  = !run;
    assign rx_valid_o  = rx_done;
    assign abort_o     = tp_q.abort;
    assign err_break_o = tp_q.eb;
    assign err_frame_o = tp_q.ef;
    assign err_coll_o  = tp_q.ec;

    // R2: nothing is delivered without a learned rate
    a_r2_rx_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> locked_o);
    // R4: a transmit only begins with a learned rate
    a_r4_tx_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_busy_o) |-> locked_o);
    // R8: an abort carries exactly one cause
    a_r8_one_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> $onehot({err_break_o, err_frame_o, err_coll_o}));
    // R8: the rate is forgotten right after an abort
    a_r8_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> !locked_o);
    // R9: the break answer starts as the link enters reset
    a_r9_answer_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(link_rst_o) |-> pull_low_o);
    // R10: the link leaves reset only after seeing the wire high
    a_r10_release_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(link_rst_o) |-> $past(line_i));
    // R3: receive and transmit never overlap on the shared wire
    a_r3_half_duplex: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rx_busy && tx_busy_o));
endmodule

// File: tb/dbg_link_guard_tb.sv
module dbg_link_guard_tb;
    localparam int BRK = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_low;
    logic       line;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_busy, pull_low, rx_valid, abort_p, link_rst, locked;
    logic       e_brk, e_frm, e_coll;
    logic [7:0] rx_data;

    always #4 clk = ~clk;
    assign line = !(pull_low || host_low);

    dbg_link_guard u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .line_i      (line),
        .tx_data_i   (tx_data),
        .tx_valid_i  (tx_valid),
        .tx_busy_o   (tx_busy),
        .pull_low_o  (pull_low),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .abort_o     (abort_p),
        .link_rst_o  (link_rst),
        .locked_o    (locked),
        .err_break_o (e_brk),
        .err_frame_o (e_frm),
        .err_coll_o  (e_coll)
    );

    int n_tests = 0, n_fail = 0;
    int bitlen = 16;
    int rx_cnt = 0, n_abort = 0, n_brk = 0, n_frm = 0, n_coll = 0;
    int run_len = 0, last_run = 0;
    logic [7:0] rx_last = 8'h00;

    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
        if (abort_p) n_abort++;
        if (e_brk)   n_brk++;
        if (e_frm)   n_frm++;
        if (e_coll)  n_coll++;
        if (pull_low) run_len++;
        else if (run_len != 0) begin last_run = run_len; run_len = 0; end
    end

    function automatic logic [9:0] frame(input logic [7:0] b, input logic stop);
        return {stop, b, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic host_send(input logic [9:0] f);
        for (int i = 0; i < 10; i++) begin
            host_low = !f[i];
            repeat (bitlen) @(negedge clk);
        end
        host_low = 1'b0;
    endtask

    task automatic gap();
        repeat (bitlen) @(negedge clk);
    endtask

    task automatic wait_link_up();
        for (int i = 0; i < 20000; i++) begin
            if (!link_rst) break;
            @(negedge clk);
        end
    endtask

    task automatic rx_one(input logic [7:0] b);
        int c0;
        c0 = rx_cnt;
        host_send(frame(b, 1'b1));
        check(rx_cnt == c0 + 1 && rx_last == b, "R3", "received byte",
              int'(rx_last), int'(b));
        gap();
    endtask

    task automatic tx_one(input logic [7:0] b);
        logic [9:0] seen;
        logic [9:0] exp;
        exp = frame(b, 1'b1);
        seen = '0;
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (pull_low) break;
            @(negedge clk);
        end
        repeat (bitlen / 2) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            seen[k] = line;
            if (k < 9) repeat (bitlen) @(negedge clk);
        end
        check(seen == exp, "R4", "sent frame", int'(seen), int'(exp));
        for (int i = 0; i < 100; i++) begin
            if (!tx_busy) break;
            @(negedge clk);
        end
        gap();
    endtask

    task automatic relock(input int bl);
        bitlen = bl;
        host_send(frame(8'h80, 1'b1));
        check(locked == 1'b1, "R1", "lock after sync", int'(locked), 1);
        gap();
    endtask

    initial begin
        int c0, a0, f0;
        logic [31:0] r;
        r = $urandom(32'd2024);
        rst_n = 1'b0; host_low = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pull_low && !rx_valid && !locked && !link_rst && !tx_busy,
              "R1", "reset state", int'({pull_low, locked, link_rst}), 0);

        // R4: transmit request with no rate has no effect on the wire
        tx_data = 8'h00; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(last_run == 0 && run_len == 0 && !tx_busy, "R4", "unlocked tx ignored",
              last_run, 0);

        // R2: short low runs neither lock nor deliver
        c0 = rx_cnt;
        host_send(frame(8'h55, 1'b1));
        gap();
        check(!locked && rx_cnt == c0, "R2", "0x55 before lock", int'(locked), 0);

        // R1 / R2: sync locks, sync byte itself not delivered
        c0 = rx_cnt;
        relock(16);
        check(rx_cnt == c0, "R2", "sync not delivered", rx_cnt - c0, 0);

        rx_one(8'h00);
        rx_one(8'hFF);
        for (int i = 0; i < 12; i++) rx_one(8'($urandom));
        tx_one(8'hA5);
        for (int i = 0; i < 5; i++) tx_one(8'($urandom));

        // R5: low stop bit after mixed data
        f0 = n_frm; a0 = n_abort;
        host_send(frame(8'hA5, 1'b0));
        check(link_rst == 1'b1, "R10", "reset during answer", int'(link_rst), 1);
        wait_link_up();
        @(negedge clk);
        check(n_frm == f0 + 1 && n_brk == 0, "R5", "framing flag", n_frm - f0, 1);
        check(n_abort == a0 + 1 && !locked, "R8", "abort and unlock (frame)",
              n_abort - a0, 1);
        check(last_run == BRK, "R9", "answer length (frame)", last_run, BRK);

        // R6: long held-low wire, then relearn at another rate
        relock(16);
        a0 = n_abort;
        host_low = 1'b1;
        repeat (6000) @(negedge clk);
        check(link_rst == 1'b1 && !pull_low, "R10", "held while host low",
              int'(link_rst), 1);
        check(n_brk == 1 && n_frm == f0 + 1, "R6", "break flag", n_brk, 1);
        check(last_run == BRK, "R9", "answer length (break)", last_run, BRK);
        host_low = 1'b0;
        repeat (3) @(negedge clk);
        check(!link_rst && !locked, "R10", "release after high", int'(link_rst), 0);
        check(n_abort == a0 + 1, "R8", "abort (break)", n_abort - a0, 1);
        c0 = rx_cnt;
        host_send(frame(8'h55, 1'b1));
        gap();
        check(!locked && rx_cnt == c0, "R2", "0x55 after break", int'(locked), 0);
        relock(24);
        for (int i = 0; i < 8; i++) rx_one(8'($urandom));
        for (int i = 0; i < 3; i++) tx_one(8'($urandom));

        // R7: host pulls low during a released bit
        a0 = n_abort;
        tx_data = 8'hFF; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (3 * bitlen) @(negedge clk);
        host_low = 1'b1;
        repeat (2 * bitlen) @(negedge clk);
        host_low = 1'b0;
        wait_link_up();
        @(negedge clk);
        check(n_coll == 1 && !tx_busy, "R7", "collision flag", n_coll, 1);
        check(n_abort == a0 + 1 && !locked, "R8", "abort and unlock (coll)",
              n_abort - a0, 1);
        check(last_run == BRK, "R9", "answer length (coll)", last_run, BRK);
        check(n_abort == n_brk + n_frm + n_coll, "R8", "one cause per abort",
              n_abort, n_brk + n_frm + n_coll);

        relock(16);
        rx_one(8'h3C);
        tx_one(8'hC3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule